// File: doc/BRIEF.md
# Camera Serial Transmitter Register Bank

This block is the register bank of a camera serial transmitter. It sits on a simple 32-bit read/write bus, decodes word addresses and holds the settings that the packet datapath and the PHY wrapper use. It also reports a fixed capability word, and it drives three control outputs: a configuration-mode level, a one-cycle soft-reset pulse and a run level.

Per-stream settings are the data type, the line format and the input FIFO fill threshold. Software writes them only while configuration mode is held. A soft-reset request clears those settings and the PHY configuration. The usual sequence is: enter configuration mode with a reset, program the PHY and the streams, then write zero to the control register to start. Writing the configuration and reset bits together stops the transmitter.

Read data is registered and appears one cycle after the read strobe. The bus has no error response.

Top module: `cstx_regbank`

## Requirements
- R1: Offset 0x00 reads a constant capability word: bits 2:0 give the lane count, bit 3 is set when a PHY is built in, bits 6:4 give the stream count, and all other bits are zero. Writes to it have no effect.
- R2: Control register at 0x20. Bit 2 is the configuration request: it is held, driven on `cfg_req_o` and read back in bit 2.
- R3: Control bit 1 is the soft-reset request. A write with it set raises `srst_o` for exactly the next cycle, during which bit 1 reads back as 1. It then clears by itself unless it is written again.
- R4: During the cycle `srst_o` is high, every per-stream register and the PHY configuration register are cleared to zero at the next edge. A write to any of them in that same cycle is lost. The wakeup count and the control bits are not cleared.
- R5: A control write with bits 2 and 1 both clear sets `run_o`. A control write with bit 2 set clears `run_o`, so writing both bits together stops the transmitter, enters configuration mode and pulses the reset. A write of bit 1 alone leaves `run_o` unchanged.
- R6: PHY configuration at 0x28 stores bits 16:0, drives `phy_cfg_o` and reads bits 31:17 as zero.
- R7: ULPS wakeup count at 0x2C stores bits 15:0, drives `wakeup_o` and is changed only by a write to 0x2C.
- R8: The data type of stream n lives at 0x80 + 8n as 6 bits in positions 7:2. Bits 1:0 and 31:8 read as zero.
- R9: The line format of stream n lives at 0x84 + 8n, with bytes per line in bits 31:16 and the maximum line number in bits 15:0.
- R10: The FIFO threshold of stream n lives at 0x100 + 4n as 5 bits in positions 4:0.
- R11: A write to any per-stream register is ignored while the configuration request is clear.
- R12: A read of any unmapped offset returns zero, with no error. This covers unaligned offsets and stream slots at or beyond the stream count.
- R13: Read data is registered. It reflects the register state before the edge at which the read strobe is sampled, and it holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cfg_req_o | output | 1 | Configuration mode level |
| srst_o | output | 1 | One-cycle soft-reset pulse |
| run_o | output | 1 | Transmitter run level |
| phy_cfg_o | output | 17 | PHY configuration |
| wakeup_o | output | 16 | ULPS wakeup cycle count |
| stream_dt_o | output | NUM_STREAMS*6 | Data type per stream |
| stream_bpl_o | output | NUM_STREAMS*16 | Bytes per line per stream |
| stream_lines_o | output | NUM_STREAMS*16 | Maximum line number per stream |
| stream_fill_o | output | NUM_STREAMS*5 | FIFO fill threshold per stream |

## Verification
The soft-reset clear and a register write can land on the same edge. This happens when a bus write reaches a stream register or the PHY configuration in the cycle right after a control write with bit 1 set. The bench provokes this both in a directed sequence and through random back-to-back control and register writes. Its model applies the clear first and discards the colliding write, and the readback and the output ports are judged against that model. A read issued in the pulse cycle must also see the reset bit set and the old register contents, because the clear only lands at that same edge.

// File: rtl/cstx_pkg.sv
package cstx_pkg;
  localparam int DT_W   = 6;
  localparam int FILL_W = 5;
  localparam int PHY_W  = 17;
  localparam int WAKE_W = 16;
  localparam int HALF_W = 16;

  localparam int A_CAP       = 'h000;
  localparam int A_CTRL      = 'h020;
  localparam int A_PHY       = 'h028;
  localparam int A_WAKE      = 'h02C;
  localparam int A_DT        = 'h080;
  localparam int A_FMT       = 'h084;
  localparam int A_FILL      = 'h100;
  localparam int SLOT_STRIDE = 8;
  localparam int FILL_STRIDE = 4;

  function automatic logic [31:0] cap_word(int lanes, int streams, bit phy);
    return {25'd0, 3'(streams), phy, 3'(lanes)};
  endfunction

  function automatic logic [31:0] dt_view(logic [DT_W-1:0] v);
    return {{(32-DT_W-2){1'b0}}, v, 2'b00};
  endfunction

  function automatic logic [31:0] ctrl_view(logic cfg, logic srst);
    return {29'd0, cfg, srst, 1'b0};
  endfunction
endpackage

// File: rtl/cstx_decode.sv
module cstx_decode
  import cstx_pkg::*;
#(
  parameter int NS = 4,
  parameter int AW = 12
) (
  input  logic [AW-1:0] addr,
  output logic          hit_cap,
  output logic          hit_ctrl,
  output logic          hit_phy,
  output logic          hit_wake,
  output logic [NS-1:0] hit_dt,
  output logic [NS-1:0] hit_fmt,
  output logic [NS-1:0] hit_fill
);
  assign hit_cap  = (addr == AW'(A_CAP));
  assign hit_ctrl = (addr == AW'(A_CTRL));
  assign hit_phy  = (addr == AW'(A_PHY));
  assign hit_wake = (addr == AW'(A_WAKE));

  for (genvar g = 0; g < NS; g++) begin : g_slot
    assign hit_dt[g]   = (addr == AW'(A_DT + SLOT_STRIDE * g));
    assign hit_fmt[g]  = (addr == AW'(A_FMT + SLOT_STRIDE * g));
    assign hit_fill[g] = (addr == AW'(A_FILL + FILL_STRIDE * g));
  end
endmodule

// File: rtl/cstx_ctrl.sv
module cstx_ctrl
  import cstx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_phy,
  input  logic              wr_wake,
  input  logic [PHY_W-1:0]  wdata,
  output logic              cfg_q,
  output logic              srst_q,
  output logic              run_q,
  output logic [PHY_W-1:0]  phy_q,
  output logic [WAKE_W-1:0] wake_q
);
  logic start_req, stop_req;
  assign start_req = wr_ctrl && (wdata[2:1] == 2'b00);
  assign stop_req  = wr_ctrl && wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= 1'b0;
      srst_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      srst_q <= wr_ctrl && wdata[1];
      if (wr_ctrl) cfg_q <= wdata[2];
      if (start_req) run_q <= 1'b1;
      else if (stop_req) run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phy_q <= '0;
    else if (srst_q) phy_q <= '0;
    else if (wr_phy) phy_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= '0;
    else if (wr_wake) wake_q <= wdata[WAKE_W-1:0];
  end
endmodule

// File: rtl/cstx_stream_slot.sv
module cstx_stream_slot
  import cstx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_dt,
  input  logic              wr_fmt,
  input  logic              wr_fill,
  input  logic [31:0]       wdata,
  output logic [DT_W-1:0]   dt_q,
  output logic [HALF_W-1:0] bpl_q,
  output logic [HALF_W-1:0] lines_q,
  output logic [FILL_W-1:0] fill_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dt_q    <= '0;
      bpl_q   <= '0;
      lines_q <= '0;
      fill_q  <= '0;
    end else if (clr) begin
      dt_q    <= '0;
      bpl_q   <= '0;
      lines_q <= '0;
      fill_q  <= '0;
    end else begin
      if (wr_dt)   dt_q <= wdata[DT_W+1:2];
      if (wr_fmt) begin
        bpl_q   <= wdata[31:16];
        lines_q <= wdata[15:0];
      end
      if (wr_fill) fill_q <= wdata[FILL_W-1:0];
    end
  end
endmodule

// File: rtl/cstx_regbank.sv
module cstx_regbank
  import cstx_pkg::*;
#(
  parameter int NUM_LANES   = 4,
  parameter int NUM_STREAMS = 4,
  parameter bit HAS_PHY     = 1'b1,
  parameter int AW          = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr_en,
  input  logic                          bus_rd_en,
  input  logic [AW-1:0]                 bus_addr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  output logic                          cfg_req_o,
  output logic                          srst_o,
  output logic                          run_o,
  output logic [PHY_W-1:0]              phy_cfg_o,
  output logic [WAKE_W-1:0]             wakeup_o,
  output logic [NUM_STREAMS*DT_W-1:0]   stream_dt_o,
  output logic [NUM_STREAMS*HALF_W-1:0] stream_bpl_o,
  output logic [NUM_STREAMS*HALF_W-1:0] stream_lines_o,
  output logic [NUM_STREAMS*FILL_W-1:0] stream_fill_o
);
  localparam int NS = NUM_STREAMS;
  localparam logic [31:0] CAP = cap_word(NUM_LANES, NUM_STREAMS, HAS_PHY);

  logic          hit_cap, hit_ctrl, hit_phy, hit_wake;
  logic [NS-1:0] hit_dt, hit_fmt, hit_fill;
  logic          cfg_q, srst_q, run_q;
  logic          stream_wr_ok;

  logic [DT_W-1:0]   dt_q    [NS];
  logic [HALF_W-1:0] bpl_q   [NS];
  logic [HALF_W-1:0] lines_q [NS];
  logic [FILL_W-1:0] fill_q  [NS];

  cstx_decode #(.NS(NS), .AW(AW)) u_dec (
    .addr    (bus_addr),
    .hit_cap (hit_cap),
    .hit_ctrl(hit_ctrl),
    .hit_phy (hit_phy),
    .hit_wake(hit_wake),
    .hit_dt  (hit_dt),
    .hit_fmt (hit_fmt),
    .hit_fill(hit_fill)
  );

  cstx_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ctrl(bus_wr_en && hit_ctrl),
    .wr_phy (bus_wr_en && hit_phy),
    .wr_wake(bus_wr_en && hit_wake),
    .wdata  (bus_wdata[PHY_W-1:0]),
    .cfg_q  (cfg_q),
    .srst_q (srst_q),
    .run_q  (run_q),
    .phy_q  (phy_cfg_o),
    .wake_q (wakeup_o)
  );

  // per-stream writes pass only in configuration mode
  assign stream_wr_ok = bus_wr_en && cfg_q;

  for (genvar g = 0; g < NS; g++) begin : g_stream
    cstx_stream_slot u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (srst_q),
      .wr_dt  (stream_wr_ok && hit_dt[g]),
      .wr_fmt (stream_wr_ok && hit_fmt[g]),
      .wr_fill(stream_wr_ok && hit_fill[g]),
      .wdata  (bus_wdata),
      .dt_q   (dt_q[g]),
      .bpl_q  (bpl_q[g]),
      .lines_q(lines_q[g]),
      .fill_q (fill_q[g])
    );
    assign stream_dt_o[g*DT_W +: DT_W]       = dt_q[g];
    assign stream_bpl_o[g*HALF_W +: HALF_W]   = bpl_q[g];
    assign stream_lines_o[g*HALF_W +: HALF_W] = lines_q[g];
    assign stream_fill_o[g*FILL_W +: FILL_W] = fill_q[g];
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit_cap)  rd_mux = CAP;
    if (hit_ctrl) rd_mux = ctrl_view(cfg_q, srst_q);
    if (hit_phy)  rd_mux = 32'(phy_cfg_o);
    if (hit_wake) rd_mux = 32'(wakeup_o);
    for (int i = 0; i < NS; i++) begin
      if (hit_dt[i])   rd_mux = dt_view(dt_q[i]);
      if (hit_fmt[i])  rd_mux = {bpl_q[i], lines_q[i]};
      if (hit_fill[i]) rd_mux = 32'(fill_q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd_en) bus_rdata <= rd_mux;
  end

  assign cfg_req_o = cfg_q;
  assign srst_o    = srst_q;
  assign run_o     = run_q;
endmodule

// File: rtl/cstx_regbank_chk.sv
module cstx_regbank_chk
  import cstx_pkg::*;
#(
  parameter int NUM_LANES   = 4,
  parameter int NUM_STREAMS = 4,
  parameter bit HAS_PHY     = 1'b1,
  parameter int AW          = 12
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_wr_en,
  input logic                          bus_rd_en,
  input logic [AW-1:0]                 bus_addr,
  input logic [31:0]                   bus_wdata,
  input logic [31:0]                   bus_rdata,
  input logic                          cfg_req_o,
  input logic                          srst_o,
  input logic                          run_o,
  input logic [PHY_W-1:0]              phy_cfg_o,
  input logic [WAKE_W-1:0]             wakeup_o,
  input logic [NUM_STREAMS*DT_W-1:0]   stream_dt_o,
  input logic [NUM_STREAMS*HALF_W-1:0] stream_bpl_o,
  input logic [NUM_STREAMS*HALF_W-1:0] stream_lines_o,
  input logic [NUM_STREAMS*FILL_W-1:0] stream_fill_o
);
  localparam logic [31:0] CAP_EXP = {25'd0, 3'(NUM_STREAMS), HAS_PHY, 3'(NUM_LANES)};

  logic ctrl_wr;
  assign ctrl_wr = bus_wr_en && (bus_addr == AW'(A_CTRL));

  p_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && bus_addr == AW'(A_CAP)) |=> (bus_rdata == CAP_EXP));

  p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_o && !(ctrl_wr && bus_wdata[1])) |=> !srst_o);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    srst_o |=> (phy_cfg_o == '0 && stream_dt_o == '0 && stream_bpl_o == '0 &&
                stream_lines_o == '0 && stream_fill_o == '0));

  p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[2]) |=> (!run_o && cfg_req_o));

  p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_en && bus_addr == AW'(A_WAKE)) |=> $stable(wakeup_o));

  p_fmt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == AW'(A_FMT) && cfg_req_o && !srst_o)
      |=> ({stream_bpl_o[HALF_W-1:0], stream_lines_o[HALF_W-1:0]} == $past(bus_wdata)));

  p_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_req_o && !srst_o) |=> ($stable(stream_dt_o) && $stable(stream_bpl_o) &&
                                 $stable(stream_lines_o) && $stable(stream_fill_o)));

  p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> $stable(bus_rdata));

  p_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[2:1] == 2'b00) |=> (run_o && !cfg_req_o));
endmodule

bind cstx_regbank cstx_regbank_chk #(
  .NUM_LANES(NUM_LANES), .NUM_STREAMS(NUM_STREAMS), .HAS_PHY(HAS_PHY), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .cfg_req_o(cfg_req_o), .srst_o(srst_o), .run_o(run_o), .phy_cfg_o(phy_cfg_o),
  .wakeup_o(wakeup_o), .stream_dt_o(stream_dt_o), .stream_bpl_o(stream_bpl_o),
  .stream_lines_o(stream_lines_o), .stream_fill_o(stream_fill_o)
);

// File: tb/sim_cstx_regbank.sv
module sim_cstx_regbank;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cfg_o, srst_o, run_o;
  logic [16:0] phy_o;
  logic [15:0] wake_o;
  logic [NS*6-1:0]  dt_o;
  logic [NS*16-1:0] bpl_o, lines_o;
  logic [NS*5-1:0]  fill_o;

  always #2.5 clk = ~clk;

  cstx_regbank u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(wr_en), .bus_rd_en(rd_en),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
    .cfg_req_o(cfg_o), .srst_o(srst_o), .run_o(run_o), .phy_cfg_o(phy_o),
    .wakeup_o(wake_o), .stream_dt_o(dt_o), .stream_bpl_o(bpl_o),
    .stream_lines_o(lines_o), .stream_fill_o(fill_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [5:0]  m_dt   [NS];
  logic [31:0] m_fmt  [NS];
  logic [4:0]  m_fill [NS];
  logic [16:0] m_phy;
  logic [15:0] m_wake;
  logic        m_cfg, m_srst, m_run;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] a_dt(int n);   return 12'(128 + 8*n); endfunction
  function automatic logic [11:0] a_fmt(int n);  return 12'(132 + 8*n); endfunction
  function automatic logic [11:0] a_fill(int n); return 12'(256 + 4*n); endfunction

  // expected readback computed from the register map
  function automatic logic [31:0] f_rd(logic [11:0] a);
    if (a == 12'h000) return 32'h0000_004C;
    if (a == 12'h020) return {29'd0, m_cfg, m_srst, 1'b0};
    if (a == 12'h028) return {15'd0, m_phy};
    if (a == 12'h02C) return {16'd0, m_wake};
    for (int n = 0; n < NS; n++) begin
      if (a == a_dt(n))   return {24'd0, m_dt[n], 2'b00};
      if (a == a_fmt(n))  return m_fmt[n];
      if (a == a_fill(n)) return {27'd0, m_fill[n]};
    end
    return 32'd0;
  endfunction

  function automatic string f_tag(logic [11:0] a);
    if (a == 12'h000) return "R1";
    if (a == 12'h020) return "R2";
    if (a == 12'h028) return "R6";
    if (a == 12'h02C) return "R7";
    for (int n = 0; n < NS; n++) begin
      if (a == a_dt(n))   return "R8";
      if (a == a_fmt(n))  return "R9";
      if (a == a_fill(n)) return "R10";
    end
    return "R12";
  endfunction

  task automatic model_step(bit is_wr, logic [11:0] a, logic [31:0] d);
    bit pulse   = m_srst;
    bit cfg_old = m_cfg;
    bit nsrst   = 0;
    if (pulse) begin
      m_phy = '0;
      for (int n = 0; n < NS; n++) begin
        m_dt[n] = '0; m_fmt[n] = '0; m_fill[n] = '0;
      end
    end
    if (is_wr) begin
      if (a == 12'h020) begin
        m_cfg = d[2];
        nsrst = d[1];
        if (d[2:1] == 2'b00) m_run = 1'b1;
        else if (d[2]) m_run = 1'b0;
      end
      if (a == 12'h028 && !pulse) m_phy = d[16:0];
      if (a == 12'h02C) m_wake = d[15:0];
      for (int n = 0; n < NS; n++) begin
        if (cfg_old && !pulse) begin
          if (a == a_dt(n))   m_dt[n] = d[7:2];
          if (a == a_fmt(n))  m_fmt[n] = d;
          if (a == a_fill(n)) m_fill[n] = d[4:0];
        end
      end
    end
    m_srst = nsrst;
  endtask

  task automatic cmp_ports();
    chk("R2 cfg_req_o", 32'(cfg_o), 32'(m_cfg));
    chk("R3 srst_o", 32'(srst_o), 32'(m_srst));
    chk("R5 run_o", 32'(run_o), 32'(m_run));
    chk("R6 phy_cfg_o", 32'(phy_o), 32'(m_phy));
    chk("R7 wakeup_o", 32'(wake_o), 32'(m_wake));
    for (int n = 0; n < NS; n++) begin
      chk("R8/R4 stream_dt_o", 32'(dt_o[n*6 +: 6]), 32'(m_dt[n]));
      chk("R9/R4 stream fmt", {bpl_o[n*16 +: 16], lines_o[n*16 +: 16]}, m_fmt[n]);
      chk("R10/R4 stream_fill_o", 32'(fill_o[n*5 +: 5]), 32'(m_fill[n]));
    end
  endtask

  // one bus cycle, called at a falling edge
  task automatic op(bit is_wr, logic [11:0] a, logic [31:0] d);
    logic [31:0] exp = f_rd(a);
    wr_en = is_wr; rd_en = !is_wr; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    model_step(is_wr, a, d);
    if (!is_wr) chk({f_tag(a), " R13 readback"}, rdata, exp);
    cmp_ports();
  endtask

  task automatic idle();
    @(negedge clk);
    model_step(1'b0, 12'h3FC, 32'd0);
  endtask

  task automatic rd_expect(logic [11:0] a, logic [31:0] exp, string tag);
    wr_en = 1'b0; rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    model_step(1'b0, a, 32'd0);
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    for (int n = 0; n < NS; n++) begin
      m_dt[n] = '0; m_fmt[n] = '0; m_fill[n] = '0;
    end
    m_phy = '0; m_wake = '0; m_cfg = 0; m_srst = 0; m_run = 0;

    repeat (3) @(negedge clk);
    chk("reset rdata R13", rdata, 32'd0);
    cmp_ports();
    rst_n = 1'b1;
    @(negedge clk);

    // R1: capability constant, write ignored
    op(1'b0, 12'h000, 0);
    op(1'b1, 12'h000, 32'hFFFF_FFFF);
    rd_expect(12'h000, 32'h0000_004C, "R1 capability after write");

    // R11: stream writes outside configuration mode are dropped
    op(1'b1, a_fill(0), 32'h1F);
    rd_expect(a_fill(0), 32'd0, "R11 gated fill write");
    op(1'b1, a_dt(2), 32'hFC);
    rd_expect(a_dt(2), 32'd0, "R11 gated dt write");

    // R2/R8/R9/R10: program in configuration mode
    op(1'b1, 12'h020, 32'h4);
    op(1'b1, a_dt(1), 32'hFFFF_FFFF);
    rd_expect(a_dt(1), 32'h0000_00FC, "R8 dt field and zero bits");
    op(1'b1, a_fmt(3), 32'h0F00_02D1);
    rd_expect(a_fmt(3), 32'h0F00_02D1, "R9 line format");
    op(1'b1, a_fill(2), 32'hFFFF_FFE4);
    rd_expect(a_fill(2), 32'h0000_0004, "R10 fill field");
    op(1'b1, 12'h028, 32'hFFFF_FFFF);
    rd_expect(12'h028, 32'h0001_FFFF, "R6 upper bits zero");
    op(1'b1, 12'h02C, 32'hABCD_0020);
    rd_expect(12'h02C, 32'h0000_0020, "R7 wakeup count");

    // R12: unmapped, unaligned and out-of-range stream slots
    rd_expect(12'h022, 32'd0, "R12 unaligned");
    rd_expect(a_dt(NS), 32'd0, "R12 stream slot beyond count");
    rd_expect(a_fill(NS), 32'd0, "R12 fill slot beyond count");
    rd_expect(12'h040, 32'd0, "R12 hole");

    // R5: start
    op(1'b1, 12'h020, 32'h0);
    chk("R5 run after zero write", 32'(run_o), 32'd1);
    op(1'b1, 12'h020, 32'h2);
    chk("R5 reset alone keeps run", 32'(run_o), 32'd1);
    chk("R3 pulse high", 32'(srst_o), 32'd1);
    idle();
    chk("R3 pulse self-clears", 32'(srst_o), 32'd0);
    rd_expect(a_fmt(3), 32'd0, "R4 cleared by reset");
    rd_expect(12'h02C, 32'h0000_0020, "R4 wakeup survives reset");

    // R3/R4/R5: stop, then collide a write with the pulse
    op(1'b1, 12'h020, 32'h4);
    op(1'b1, a_dt(0), 32'h0000_00A8);
    op(1'b1, 12'h020, 32'h6);
    chk("R5 stop clears run", 32'(run_o), 32'd0);
    op(1'b1, a_dt(0), 32'h0000_0054);
    rd_expect(a_dt(0), 32'd0, "R4 write lost in pulse cycle");
    op(1'b1, 12'h020, 32'h6);
    rd_expect(12'h020, 32'h0000_0006, "R3 reset bit visible in pulse cycle");
    rd_expect(12'h020, 32'h0000_0004, "R3 reset bit cleared");

    // R13: rdata holds without a read
    op(1'b1, 12'h02C, 32'h1234);
    idle();
    chk("R13 rdata held", rdata, 32'h0000_0004);

    // random mix
    for (int k = 0; k < 600; k++) begin
      int sel = $urandom_range(0, 9);
      int n   = $urandom_range(0, NS + 1);
      logic [11:0] a;
      logic [31:0] d = $urandom;
      case (sel)
        0: a = 12'h000;
        1: begin
             a = 12'h020;
             d = ($urandom_range(0, 3) != 0) ? 32'h4 : (d & 32'h6);
           end
        2: a = 12'h028;
        3: a = 12'h02C;
        4, 8: a = a_dt(n);
        5: a = a_fmt(n);
        6, 9: a = a_fill(n);
        default: a = 12'($urandom_range(0, 1023));
      endcase
      op($urandom_range(0, 1) == 1, a, d);
    end
    idle();
    cmp_ports();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule